// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Sequencer

This block drives one external asynchronous DRAM with a 4-bit data path that serves as a packet store. It runs on a 27 MHz clock and performs one random-access read or write per request. Each access is a fixed ten-clock cycle. The row address goes out on a shared 10-bit address bus, then the column address. The block generates the row strobe, two column strobes and the write-enable line, and each edge falls on a whole clock so that it lands inside its nanosecond window.

On the system side, a request carries a linear 20-bit word address, a write flag and 4 bits of write data. The sequencer takes a request only when it is idle. It answers with a one-clock acknowledge at the end of the cycle. For reads, the returned data is valid in that same clock.

A 2-bit configuration input selects the memory organisation: one large device, two small devices on separate column strobes, or one small device.

Top module: `dram_seq`

## Requirements
- R1: While reset is held and in the first idle clock after it, the outputs are in their idle state. The row strobe, both column strobes and the write line are high. The data-output enable, acknowledge and read-valid outputs are low, and req_ready is high.
- R2: A request is taken at a rising edge where req and req_ready are both high. req_ready is low for the ten clocks of the cycle (phases 0 to 9) and high again in the clock after phase 9. A request held high during the cycle starts nothing.
- R3: The row strobe is low in phases 0 to 5, which is 6 clocks, and high in phases 6 to 9, which is at least 4 clocks of precharge.
- R4: The selected column strobe is low in phases 4 to 7. It therefore falls 4 clocks after the row strobe and rises 8 clocks after it. The column strobe that is not selected stays high.
- R5: The address bus carries the row address in phases 0 and 1 and the column address in phases 2 to 9.
- R6: For a write, the write line is low and the data-output enable is high in phases 0 to 7, and the data output carries the request's write data. For a read, the write line stays high and the enable stays low.
- R7: For a read, the 4-bit DRAM input is sampled at the edge where the column strobe rises. That value is presented on rd_data while rd_valid is high.
- R8: ack is high only in phase 9. rd_valid is high only in phase 9 of a read cycle.
- R9: With cfg_sel = 2'b01 (one 1M×4 device), the row is addr[19:10] and the column is addr[9:0], and column strobe 0 is used.
- R10: With cfg_sel = 2'b11 (two 256k×4 devices), addr[18] selects the strobe: 0 selects column strobe 0 and 1 selects column strobe 1. The row is {0, addr[17:9]} and the column is {0, addr[8:0]}.
- R11: With cfg_sel = 2'b00 or 2'b10 (one 256k×4 device), the row is {0, addr[17:9]} and the column is {0, addr[8:0]}. Column strobe 0 is always used, and addr[19:18] is ignored.
- R12: Address, write flag, write data and cfg_sel are taken at acceptance. Changing them during the cycle has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst | input | 1 | synchronous reset, active high |
| cfg_sel | input | 2 | memory organisation select |
| req | input | 1 | access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | linear word address |
| req_wdata | input | 4 | write data |
| req_ready | output | 1 | high when idle and able to take a request |
| ack | output | 1 | one-clock pulse in the last clock of a cycle |
| rd_valid | output | 1 | read data valid, with ack on reads |
| rd_data | output | 4 | captured read data |
| dram_a | output | 10 | multiplexed row/column address |
| dram_ras_n | output | 1 | row strobe, active low |
| dram_cas0_n | output | 1 | column strobe for device 0, active low |
| dram_cas1_n | output | 1 | column strobe for device 1, active low |
| dram_we_n | output | 1 | write line, active low |
| dram_dq_out | output | 4 | write data to the DRAM |
| dram_dq_oe | output | 1 | enable for the data-output drivers |
| dram_dq_in | input | 4 | read data from the DRAM |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Phase offsets.** A phase off by one would shift the column strobe's fall toward the row strobe, or release the row address early. Every strobe and address value is compared in every phase.
- **Device select in the two-device mode.** A design that ignored the device-select bit, or used the wrong bit, would assert the wrong column strobe.
- **Aliasing in the single small-device mode.** A design that kept using the upper address bits would not return the value written through an aliased address.
- **Changes during a cycle.** The bench scrambles the address, data, write flag and configuration, and holds the request high, during a cycle. A design that sampled these late would corrupt the cycle or start a back-to-back cycle without the idle gap.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    MAP_SMALL = 2'd0,
    MAP_LARGE = 2'd1,
    MAP_PAIR  = 2'd2
  } map_e;

  function automatic map_e decode_sel(input logic [1:0] sel);
    case (sel)
      2'b01:   return MAP_LARGE;
      2'b11:   return MAP_PAIR;
      default: return MAP_SMALL;
    endcase
  endfunction

endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map
  import dram_seq_pkg::*;
#(
  parameter int A_W = 10
) (
  input  map_e             mode,
  input  logic [2*A_W-1:0] lin_addr,
  output logic [A_W-1:0]   row,
  output logic [A_W-1:0]   col,
  output logic             bank
);
  localparam int S_W = A_W - 1;

  always_comb begin
    row  = {1'b0, lin_addr[2*S_W-1:S_W]};
    col  = {1'b0, lin_addr[S_W-1:0]};
    bank = 1'b0;
    case (mode)
      MAP_LARGE: begin
        row = lin_addr[2*A_W-1:A_W];
        col = lin_addr[A_W-1:0];
      end
      MAP_PAIR: bank = lin_addr[2*S_W];
      default: ;
    endcase
  end

  always_comb begin
    if (mode != MAP_LARGE)
      assert_small_msb_R10: assert (row[A_W-1] == 1'b0 && col[A_W-1] == 1'b0);
    if (mode != MAP_PAIR)
      assert_single_bank_R11: assert (bank == 1'b0);
  end

endmodule

// File: rtl/dram_cycle_timer.sv
module dram_cycle_timer #(
  parameter int CYC_LEN = 10,
  localparam int C_W = $clog2(CYC_LEN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           busy,
  output logic [C_W-1:0] cnt,
  output logic           nxt_busy,
  output logic [C_W-1:0] nxt_cnt
);
  localparam logic [C_W-1:0] LAST_C = C_W'(CYC_LEN - 1);

  always_comb begin
    if (!busy) begin
      nxt_busy = start;
      nxt_cnt  = '0;
    end else if (cnt == LAST_C) begin
      nxt_busy = 1'b0;
      nxt_cnt  = '0;
    end else begin
      nxt_busy = 1'b1;
      nxt_cnt  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= nxt_busy;
      cnt  <= nxt_cnt;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= LAST_C);
  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST_C) |=> (busy && cnt == $past(cnt) + 1'b1));
  assert_cycle_end_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST_C) |=> !busy);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int A_W      = 10,
  parameter int D_W      = 4,
  parameter int CYC_LEN  = 10,
  parameter int RAS_CLKS = 6,
  parameter int CAS_AT   = 4,
  parameter int CAS_END  = 8,
  parameter int COL_AT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_sel,
  input  logic             req,
  input  logic             req_we,
  input  logic [2*A_W-1:0] req_addr,
  input  logic [D_W-1:0]   req_wdata,
  output logic             req_ready,
  output logic             ack,
  output logic             rd_valid,
  output logic [D_W-1:0]   rd_data,
  output logic [A_W-1:0]   dram_a,
  output logic             dram_ras_n,
  output logic             dram_cas0_n,
  output logic             dram_cas1_n,
  output logic             dram_we_n,
  output logic [D_W-1:0]   dram_dq_out,
  output logic             dram_dq_oe,
  input  logic [D_W-1:0]   dram_dq_in
);
  localparam int C_W = $clog2(CYC_LEN);
  localparam logic [C_W-1:0] LAST_C = C_W'(CYC_LEN - 1);
  localparam logic [C_W-1:0] RAS_C  = C_W'(RAS_CLKS);
  localparam logic [C_W-1:0] CASA_C = C_W'(CAS_AT);
  localparam logic [C_W-1:0] CASE_C = C_W'(CAS_END);
  localparam logic [C_W-1:0] CAPT_C = C_W'(CAS_END - 1);
  localparam logic [C_W-1:0] COL_C  = C_W'(COL_AT);

  logic           busy, nxt_busy, start;
  logic [C_W-1:0] cnt, nxt_cnt;
  logic [A_W-1:0] dec_row, dec_col, col_q;
  logic           dec_bank, bank_q, we_q;
  logic           cas_win, wr_win, bank_eff, last_nxt;

  assign req_ready = !busy;
  assign start     = req && !busy;

  dram_cycle_timer #(.CYC_LEN(CYC_LEN)) u_timer (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .cnt(cnt), .nxt_busy(nxt_busy), .nxt_cnt(nxt_cnt)
  );

  dram_addr_map #(.A_W(A_W)) u_map (
    .mode(decode_sel(cfg_sel)), .lin_addr(req_addr),
    .row(dec_row), .col(dec_col), .bank(dec_bank)
  );

  always_comb begin
    bank_eff = start ? dec_bank : bank_q;
    cas_win  = nxt_busy && nxt_cnt >= CASA_C && nxt_cnt < CASE_C;
    wr_win   = nxt_busy && nxt_cnt < CASE_C && (start ? req_we : we_q);
    last_nxt = nxt_busy && nxt_cnt == LAST_C;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q       <= '0;
      bank_q      <= 1'b0;
      we_q        <= 1'b0;
      dram_a      <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas0_n <= 1'b1;
      dram_cas1_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_dq_out <= '0;
      ack         <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      if (start) begin
        col_q       <= dec_col;
        bank_q      <= dec_bank;
        we_q        <= req_we;
        dram_dq_out <= req_wdata;
        dram_a      <= dec_row;
      end else if (busy && nxt_busy && nxt_cnt == COL_C) begin
        dram_a <= col_q;
      end
      dram_ras_n  <= !(nxt_busy && nxt_cnt < RAS_C);
      dram_cas0_n <= !(cas_win && !bank_eff);
      dram_cas1_n <= !(cas_win && bank_eff);
      dram_we_n   <= !wr_win;
      dram_dq_oe  <= wr_win;
      if (busy && cnt == CAPT_C && !we_q) rd_data <= dram_dq_in;
      ack      <= last_nxt;
      rd_valid <= last_nxt && !(start ? req_we : we_q);
    end
  end

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    (req && req_ready) |=> !req_ready);
  assert_cas_one_line_R4: assert property (@(posedge clk) disable iff (rst)
    !(!dram_cas0_n && !dram_cas1_n));
  assert_cas_under_ras_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas0_n) || $fell(dram_cas1_n)) |-> !dram_ras_n);
  assert_row_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |=> $stable(dram_a));
  assert_we_with_oe_R6: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> !dram_we_n);
  assert_rdv_with_ack_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ack);
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  assert_col_latched_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |-> ($stable(col_q) && $stable(bank_q)));

endmodule

// File: tb/dram_seq_bench.sv
module dram_seq_bench;
  localparam int CLK_PERIOD = 38;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_sel;
  logic        req, req_we;
  logic [19:0] req_addr;
  logic [3:0]  req_wdata;
  logic        req_ready, ack, rd_valid;
  logic [3:0]  rd_data;
  logic [9:0]  dram_a;
  logic        dram_ras_n, dram_cas0_n, dram_cas1_n, dram_we_n, dram_dq_oe;
  logic [3:0]  dram_dq_out;
  logic [3:0]  dram_dq_in = 4'h0;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_seq u_dram_seq (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_cas0_n(dram_cas0_n), .dram_cas1_n(dram_cas1_n),
    .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  // DRAM model driven only by the pins
  logic [3:0] dmem [int];
  logic [9:0] row_l = '0;
  always @(negedge dram_ras_n) row_l = dram_a;
  task automatic dram_access(input bit b);
    int key = int'({b, row_l, dram_a});
    if (!dram_we_n) dmem[key] = dram_dq_out;
    else dram_dq_in = dmem.exists(key) ? dmem[key] : 4'h0;
  endtask
  always @(negedge dram_cas0_n) dram_access(1'b0);
  always @(negedge dram_cas1_n) dram_access(1'b1);

  // Reference model from the requirements
  logic [3:0] ref_mem [int];
  function automatic bit is_large(input logic [1:0] s); return s == 2'b01; endfunction
  function automatic bit is_pair(input logic [1:0] s);  return s == 2'b11; endfunction
  function automatic logic [9:0] exp_row(input logic [1:0] s, input logic [19:0] a);
    return is_large(s) ? a[19:10] : {1'b0, a[17:9]};
  endfunction
  function automatic logic [9:0] exp_col(input logic [1:0] s, input logic [19:0] a);
    return is_large(s) ? a[9:0] : {1'b0, a[8:0]};
  endfunction
  function automatic bit exp_bank(input logic [1:0] s, input logic [19:0] a);
    return is_pair(s) ? a[18] : 1'b0;
  endfunction
  function automatic string map_tag(input logic [1:0] s);
    return is_large(s) ? "R9" : (is_pair(s) ? "R10" : "R11");
  endfunction

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic do_op(input bit we, input logic [19:0] addr, input logic [3:0] wd,
                       input logic [1:0] sel, input bit hold);
    logic [9:0] er = exp_row(sel, addr);
    logic [9:0] ec = exp_col(sel, addr);
    bit eb = exp_bank(sel, addr);
    int key = int'({eb, er, ec});
    logic [3:0] exp_rd = ref_mem.exists(key) ? ref_mem[key] : 4'h0;
    string mt = map_tag(sel);
    logic cs, co;
    req = 1; req_we = we; req_addr = addr; req_wdata = wd; cfg_sel = sel;
    chk(req_ready === 1'b1, "R2 ready before request", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    if (!hold) req = 0;
    // R12: scramble request fields after acceptance
    req_addr = 20'($urandom); req_wdata = 4'($urandom);
    cfg_sel = 2'($urandom); req_we = 1'($urandom);
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      cs = eb ? dram_cas1_n : dram_cas0_n;
      co = eb ? dram_cas0_n : dram_cas1_n;
      chk(dram_ras_n === (k >= 6), $sformatf("R3 row strobe phase %0d", k), int'(dram_ras_n), int'(k >= 6));
      chk(cs === !(k >= 4 && k < 8), $sformatf("R4 %s selected cas phase %0d", mt, k), int'(cs), int'(!(k >= 4 && k < 8)));
      chk(co === 1'b1, $sformatf("R4 %s other cas phase %0d", mt, k), int'(co), 1);
      if (k < 2) chk(dram_a === er, $sformatf("R5 %s row phase %0d", mt, k), int'(dram_a), int'(er));
      else       chk(dram_a === ec, $sformatf("R5 %s col phase %0d R12", mt, k), int'(dram_a), int'(ec));
      chk(dram_we_n === !(we && k < 8), $sformatf("R6 we_n phase %0d", k), int'(dram_we_n), int'(!(we && k < 8)));
      chk(dram_dq_oe === (we && k < 8), $sformatf("R6 oe phase %0d", k), int'(dram_dq_oe), int'(we && k < 8));
      if (we && k < 8) chk(dram_dq_out === wd, "R6 write data R12", int'(dram_dq_out), int'(wd));
      chk(req_ready === 1'b0, $sformatf("R2 busy phase %0d", k), int'(req_ready), 0);
      chk(ack === (k == 9), $sformatf("R8 ack phase %0d", k), int'(ack), int'(k == 9));
      chk(rd_valid === (!we && k == 9), $sformatf("R8 rd_valid phase %0d", k), int'(rd_valid), int'(!we && k == 9));
      if (!we && k == 9) chk(rd_data === exp_rd, $sformatf("R7 %s read data", mt), int'(rd_data), int'(exp_rd));
    end
    @(negedge clk);
    req = 0;
    chk(req_ready === 1'b1 && dram_ras_n === 1'b1 && ack === 1'b0,
        "R2 idle after cycle", int'({req_ready, dram_ras_n, ack}), 3'b110);
    if (we) ref_mem[key] = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [19:0] pool [16];
    void'($urandom(32'd2024));
    rst = 1; req = 0; req_we = 0; req_addr = '0; req_wdata = '0; cfg_sel = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dram_ras_n === 1 && dram_cas0_n === 1 && dram_cas1_n === 1 && dram_we_n === 1,
        "R1 strobes idle in reset", int'({dram_ras_n, dram_cas0_n, dram_cas1_n, dram_we_n}), 4'hF);
    chk(dram_dq_oe === 0 && ack === 0 && rd_valid === 0, "R1 outputs idle in reset",
        int'({dram_dq_oe, ack, rd_valid}), 0);
    rst = 0;
    @(negedge clk);
    chk(req_ready === 1'b1 && dram_ras_n === 1'b1, "R1 ready after reset",
        int'({req_ready, dram_ras_n}), 3);

    // Directed corners
    do_op(1, 20'hFFFFF, 4'hA, 2'b01, 0);   // R9 top corner
    do_op(1, 20'h00000, 4'h5, 2'b01, 0);
    do_op(0, 20'hFFFFF, 4'h0, 2'b01, 0);
    do_op(1, 20'h40000, 4'h3, 2'b11, 0);   // R10 second device
    do_op(1, 20'h00000, 4'hC, 2'b11, 0);   // R10 first device
    do_op(0, 20'h40000, 4'h0, 2'b11, 0);
    do_op(0, 20'h00000, 4'h0, 2'b11, 0);
    do_op(1, 20'hC0001, 4'h9, 2'b00, 0);   // R11 upper bits ignored
    do_op(0, 20'h00001, 4'h0, 2'b10, 0);   // R11 alias read
    do_op(0, 20'h80001, 4'h0, 2'b00, 1);   // R2 request held through cycle
    do_op(1, 20'h7FFFF, 4'h6, 2'b11, 1);

    // Constrained random
    for (int i = 0; i < 16; i++) pool[i] = 20'($urandom);
    for (int i = 0; i < 300; i++)
      do_op(1'($urandom), pool[$urandom % 16], 4'($urandom), 2'($urandom), ($urandom % 8) == 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule